// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between a processor's load/store request port and a 32-bit external bus. A request names an operand of one, two or four bytes at any byte address. The block issues that operand as the fewest naturally aligned bus transfers. For each transfer it drives the byte address, a size code and the byte-lane enables. It then waits for the slave to end the transfer with an acknowledge or an error, and only after that does it start the next one. On reads it gathers the returned lanes into a right-justified operand. On writes it routes each operand byte to the lane that matches its address.

An instruction fetch at an odd address is refused without any bus activity and is answered with an address-error flag. A watchdog ends any transfer that the slave leaves open too long, and reports it as a bus error. The request side uses a valid/ready handshake. Each accepted request gets exactly one single-cycle response pulse.

Top module: `misalign_splitter`

## Requirements
- R1: Every bus transfer is naturally aligned. A byte operand always takes one transfer. A word at an even offset and a longword at offset 0 also take one transfer. A word at an odd offset takes two transfers, and a longword at offset 1, 2 or 3 takes two or three.
- R2: Transfer sequences, in issue order:
  - longword at offset 1: byte, word, byte
  - longword at offset 3: byte, word, byte
  - longword at offset 2: word, word
  - word at offset 1 or 3: byte, byte

  Each transfer address is the previous transfer address plus the previous transfer size.
- R3: During a transfer, `bus_addr` is the byte address of the first byte covered. `bus_size` is 0 for a byte, 1 for a word and 2 for a longword. `bus_be[L]` is set exactly for the lanes L (L = address bits 1:0) that the transfer covers.
- R4: On writes, lane L is carried on `bus_wdata[31-8L -: 8]`. The operand is taken right-justified from `req_wdata` in big-endian order: the lowest address holds the most significant byte. Lanes that are not enabled are driven to 0.
- R5: On a successful read, `rsp_rdata` holds the operand right-justified, with the byte from the lowest address as the most significant byte. `rsp_rdata` is 0 for writes and for any error response.
- R6: While a transfer is waiting for termination, `bus_valid` stays high and address, size, enables and write data stay constant. The next transfer starts only in the cycle after an acknowledge.
- R7: An instruction fetch (`req_ifetch`=1) with `req_addr[0]`=1 starts no bus transfer. It gives `rsp_valid` with `rsp_addr_err`=1 in the cycle after acceptance.
- R8: A `bus_err` on any transfer abandons the remaining transfers. `rsp_valid` with `rsp_err`=1 follows in the next cycle. A `bus_err` in the same cycle as `bus_ack` counts as an error.
- R9: A transfer not terminated within TIMEOUT cycles (default 16) of `bus_valid` ends with `rsp_err`=1 in the following cycle. An acknowledge in the TIMEOUT-th cycle completes the transfer normally.
- R10: `req_ready` is high only when no request is in progress. Exactly one single-cycle `rsp_valid` pulse answers each accepted request. It comes in the cycle after the final termination, and `req_ready` returns in the cycle after the pulse.
- R11: During and right after reset, `req_ready`=1, `bus_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 (or 3) longword |
| req_write | input | 1 | 1 write, 0 read |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_wdata | input | 32 | Write operand, right-justified |
| rsp_valid | output | 1 | Single-cycle completion pulse |
| rsp_rdata | output | 32 | Read operand, right-justified |
| rsp_err | output | 1 | Bus error or watchdog expiry |
| rsp_addr_err | output | 1 | Misaligned instruction fetch refused |
| bus_valid | output | 1 | Transfer in progress |
| bus_addr | output | ADDR_W | Transfer byte address |
| bus_size | output | 2 | Transfer size code |
| bus_be | output | 4 | Lane enables, bit L for lane L |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data from slave |
| bus_ack | input | 1 | Transfer acknowledged |
| bus_err | input | 1 | Transfer ended in error |

## Verification
Two pairs of events can land in the same cycle. The first is the watchdog expiring in the very cycle that `bus_ack` arrives. The bench provokes it by delaying the acknowledge to exactly the TIMEOUT-th waiting cycle, and expects the split sequence to continue with no error. The second is `bus_err` arriving together with `bus_ack`. The bench drives both at once on a chosen transfer, and the response must be a single error pulse with zero data and no further transfer. Randomly chosen operands, offsets, latencies and error points are mixed with directed cases, and every transfer field is compared with a plan table held in the bench.

// File: rtl/mas_pkg.sv
package mas_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } split_state_e;

  // operand length in bytes from the request size code
  function automatic logic [2:0] op_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // largest aligned transfer that fits at this offset and remaining count
  function automatic xfer_size_e choose_size(input logic [1:0] off, input logic [2:0] left);
    if (off == 2'd0 && left >= 3'd4) return SZ_LONG;
    if (!off[0] && left >= 3'd2)     return SZ_WORD;
    return SZ_BYTE;
  endfunction

  function automatic logic [2:0] size_bytes(input xfer_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] off, input xfer_size_e s);
    logic [3:0] m;
    int lo, hi;
    m  = '0;
    lo = int'(off);
    hi = lo + int'(size_bytes(s));
    for (int l = 0; l < LANES; l++) begin
      if (l >= lo && l < hi) m[l] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/mas_planner.sv
module mas_planner
  import mas_pkg::*;
(
  input  logic [1:0]  cur_off,
  input  logic [2:0]  bytes_left,
  output xfer_size_e  xfer_size,
  output logic [2:0]  xfer_bytes,
  output logic [3:0]  xfer_be
);

  always_comb begin
    xfer_size  = choose_size(cur_off, bytes_left);
    xfer_bytes = size_bytes(xfer_size);
    xfer_be    = lane_mask(cur_off, xfer_size);
  end

endmodule

// File: rtl/mas_lane_steer.sv
module mas_lane_steer
  import mas_pkg::*;
(
  input  logic [2:0]  op_len,
  input  logic [2:0]  bytes_done,
  input  logic [1:0]  cur_off,
  input  logic [3:0]  lane_en,
  input  logic [31:0] op_wdata,
  input  logic [31:0] lane_rdata,
  input  logic [31:0] acc_in,
  output logic [31:0] lane_wdata,
  output logic [31:0] acc_out
);

  always_comb begin
    int k;
    int pos;
    lane_wdata = '0;
    acc_out    = acc_in;
    for (int l = 0; l < LANES; l++) begin
      k   = int'(bytes_done) + l - int'(cur_off);
      pos = int'(op_len) - 1 - k;
      if (lane_en[l] && pos >= 0 && pos < LANES) begin
        lane_wdata[8*(LANES-1-l) +: 8] = op_wdata[8*pos +: 8];
        acc_out[8*pos +: 8]            = lane_rdata[8*(LANES-1-l) +: 8];
      end
    end
  end

endmodule

// File: rtl/mas_watchdog.sv
module mas_watchdog #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic terminated,
  output logic expire
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!active || terminated) cnt_q <= '0;
    else if (cnt_q != LAST)        cnt_q <= cnt_q + 1'b1;
  end

  assign expire = active && !terminated && (cnt_q == LAST);

endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import mas_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_ifetch,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_addr_err,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [3:0]        bus_be,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err
);

  split_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        left_q, done_q, len_q;
  logic              write_q, err_q, aerr_q;
  logic [31:0]       wdata_q, acc_q;

  xfer_size_e  xfer_size;
  logic [2:0]  xfer_bytes;
  logic [3:0]  xfer_be;
  logic [31:0] steer_wdata, acc_next;

  // named events used by the checker
  logic accept, misfetch, in_bus, wd_expire, xfer_fail, xfer_ok, last_xfer;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign misfetch  = req_ifetch && req_addr[0];
  assign in_bus    = (state_q == ST_BUS);
  assign xfer_fail = in_bus && (bus_err || wd_expire);
  assign xfer_ok   = in_bus && bus_ack && !bus_err;
  assign last_xfer = (left_q == xfer_bytes);

  mas_planner u_plan (
    .cur_off    (addr_q[1:0]),
    .bytes_left (left_q),
    .xfer_size  (xfer_size),
    .xfer_bytes (xfer_bytes),
    .xfer_be    (xfer_be)
  );

  mas_lane_steer u_steer (
    .op_len     (len_q),
    .bytes_done (done_q),
    .cur_off    (addr_q[1:0]),
    .lane_en    (xfer_be),
    .op_wdata   (wdata_q),
    .lane_rdata (bus_rdata),
    .acc_in     (acc_q),
    .lane_wdata (steer_wdata),
    .acc_out    (acc_next)
  );

  mas_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (in_bus),
    .terminated (bus_ack || bus_err),
    .expire     (wd_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      done_q  <= '0;
      len_q   <= '0;
      write_q <= 1'b0;
      err_q   <= 1'b0;
      aerr_q  <= 1'b0;
      wdata_q <= '0;
      acc_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          len_q   <= op_bytes(req_size);
          left_q  <= op_bytes(req_size);
          done_q  <= '0;
          write_q <= req_write;
          wdata_q <= req_wdata;
          acc_q   <= '0;
          err_q   <= 1'b0;
          aerr_q  <= misfetch;
          state_q <= misfetch ? ST_RESP : ST_BUS;
        end
        ST_BUS: begin
          if (xfer_fail) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else if (xfer_ok) begin
            if (!write_q) acc_q <= acc_next;
            addr_q <= addr_q + ADDR_W'(xfer_bytes);
            left_q <= left_q - xfer_bytes;
            done_q <= done_q + xfer_bytes;
            if (last_xfer) state_q <= ST_RESP;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign bus_valid    = in_bus;
  assign bus_addr     = addr_q;
  assign bus_size     = in_bus ? xfer_size : 2'd0;
  assign bus_be       = in_bus ? xfer_be : 4'd0;
  assign bus_write    = in_bus && write_q;
  assign bus_wdata    = (in_bus && write_q) ? steer_wdata : 32'd0;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_err      = rsp_valid && err_q;
  assign rsp_addr_err = rsp_valid && aerr_q;
  assign rsp_rdata    = (rsp_valid && !err_q && !aerr_q && !write_q) ? acc_q : 32'd0;

endmodule

// File: rtl/misalign_splitter_chk.sv
module misalign_splitter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ifetch,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              rsp_addr_err,
  input logic [31:0]       rsp_rdata,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              wd_expire
);

  assert_xfer_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_size == 2'd2 ? bus_addr[1:0] == 2'b00 :
                   (bus_size == 2'd1 ? !bus_addr[0] : 1'b1)));

  assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(bus_be) == (bus_size == 2'd2 ? 4 : (bus_size == 2'd1 ? 2 : 1))));

  assert_first_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_be[bus_addr[1:0]]);

  assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ack && !bus_err && !wd_expire) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_size) && $stable(bus_be) && $stable(bus_wdata)));

  assert_misfetch_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_ifetch && req_addr[0]) |=> (!bus_valid && rsp_valid && rsp_addr_err));

  assert_err_ends_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_err) |=> (rsp_valid && rsp_err && !bus_valid && rsp_rdata == 32'd0));

  assert_watchdog_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (rsp_valid && rsp_err));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid || rsp_valid) |-> !req_ready);

endmodule

bind misalign_splitter misalign_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_ifetch   (req_ifetch),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .rsp_addr_err (rsp_addr_err),
  .rsp_rdata    (rsp_rdata),
  .bus_valid    (bus_valid),
  .bus_addr     (bus_addr),
  .bus_size     (bus_size),
  .bus_be       (bus_be),
  .bus_wdata    (bus_wdata),
  .bus_ack      (bus_ack),
  .bus_err      (bus_err),
  .wd_expire    (wd_expire)
);

// File: tb/sim_misalign_splitter.sv
`timescale 1ns/1ps
module sim_misalign_splitter;

  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_ifetch;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        rsp_valid, rsp_err, rsp_addr_err;
  logic [31:0] rsp_rdata;
  logic        bus_valid, bus_write, bus_ack, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic [3:0]  bus_be;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  misalign_splitter #(.ADDR_W(32), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_ifetch(req_ifetch),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_addr_err(rsp_addr_err),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_be(bus_be), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory contents seen by reads
  function automatic logic [7:0] memb(input logic [31:0] a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // explicit split table: size in bytes of transfer t, 0 past the end
  function automatic int plan_sz(input int n, input int o, input int t);
    case (n)
      1: return (t == 0) ? 1 : 0;
      2: if (o % 2 == 0) return (t == 0) ? 2 : 0;
         else            return (t < 2) ? 1 : 0;
      default:
        if (o == 0)      return (t == 0) ? 4 : 0;
        else if (o == 2) return (t < 2) ? 2 : 0;
        else             return (t == 1) ? 2 : ((t < 3) ? 1 : 0);
    endcase
  endfunction

  function automatic logic [3:0] exp_be(input int o, input int s);
    logic [3:0] m = 4'b0;
    for (int l = 0; l < 4; l++) if (l >= o && l < o + s) m[l] = 1'b1;
    return m;
  endfunction

  task automatic do_op(input logic [31:0] a, input logic [1:0] sz, input bit wr, input bit ifet,
                       input logic [31:0] wd, input int lat, input int err_at, input bit both,
                       input int to_at);
    int n, o, t, s;
    logic [31:0] cur, exp_op, exp_w, rd;
    bit ended;
    n = (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
    o = int'(a[1:0]);
    exp_op = 32'd0;
    for (int k = 0; k < n; k++) exp_op[8*(n-1-k) +: 8] = memb(a + 32'(k));

    @(negedge clk);
    chk(req_ready, "R10 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_ifetch = ifet; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;

    if (ifet && a[0]) begin
      chk(rsp_valid && rsp_addr_err && !bus_valid && !rsp_err, "R7 misfetch refused",
          {29'd0, bus_valid, rsp_valid, rsp_addr_err}, 32'd3);
    end else begin
      cur = a;
      ended = 1'b0;
      t = 0;
      while (!ended && plan_sz(n, o, t) != 0) begin
        s = plan_sz(n, o, t);
        chk(bus_valid && !rsp_valid, "R2 transfer issued", {31'd0, bus_valid}, 32'd1);
        chk(bus_addr == cur, "R2 transfer address", bus_addr, cur);
        chk(bus_size == ((s == 1) ? 2'd0 : ((s == 2) ? 2'd1 : 2'd2)), "R3 size code",
            {30'd0, bus_size}, 32'(s));
        chk(bus_be == exp_be(int'(cur[1:0]), s), "R3 lane enables",
            {28'd0, bus_be}, {28'd0, exp_be(int'(cur[1:0]), s)});
        if (wr) begin
          exp_w = 32'd0;
          for (int l = 0; l < 4; l++) if (bus_be[l]) begin
            int k;
            k = int'({bus_addr[31:2], 2'(l)} - a);
            exp_w[8*(3-l) +: 8] = wd[8*(n-1-k) +: 8];
          end
          chk(bus_wdata == exp_w && bus_write, "R4 write lane steering", bus_wdata, exp_w);
        end
        if (t == to_at) begin
          for (int i = 1; i <= TO; i++) begin
            @(negedge clk);
            if (i < TO)
              chk(bus_valid && !rsp_valid, "R9 still waiting", {31'd0, bus_valid}, 32'd1);
            else
              chk(rsp_valid && rsp_err && !bus_valid, "R9 watchdog error",
                  {30'd0, rsp_valid, rsp_err}, 32'd3);
          end
          ended = 1'b1;
        end else begin
          for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(bus_valid && bus_addr == cur && !rsp_valid, "R6 transfer held", bus_addr, cur);
          end
          rd = 32'd0;
          for (int l = 0; l < 4; l++)
            rd[8*(3-l) +: 8] = bus_be[l] ? memb({cur[31:2], 2'(l)}) : 8'hEE;
          bus_rdata = rd;
          if (t == err_at) begin bus_err = 1'b1; bus_ack = both; end
          else bus_ack = 1'b1;
          @(negedge clk);
          bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = 32'hDEADBEEF;
          if (t == err_at) begin
            chk(rsp_valid && rsp_err && !bus_valid && rsp_rdata == 32'd0, "R8 error ends operand",
                rsp_rdata, 32'd0);
            ended = 1'b1;
          end
          cur = cur + 32'(s);
          t++;
        end
      end
      if (!ended) begin
        chk(rsp_valid && !bus_valid && !rsp_err && !rsp_addr_err, "R1 transfer count",
            {30'd0, bus_valid, rsp_valid}, 32'd1);
        chk(rsp_rdata == (wr ? 32'd0 : exp_op), "R5 read operand", rsp_rdata, wr ? 32'd0 : exp_op);
      end
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready && !bus_valid, "R10 single response",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_ifetch = 1'b0; req_wdata = '0;
    bus_rdata = '0; bus_ack = 1'b0; bus_err = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_valid, "R11 state in reset", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_valid, "R11 state after reset", {31'd0, req_ready}, 32'd1);

    // directed corner cases
    do_op(32'h0000_1001, 2'd2, 1'b0, 1'b0, 32'h0, 0, -1, 1'b0, -1);   // R2 long@1 read
    do_op(32'h0000_2003, 2'd2, 1'b1, 1'b0, 32'hA1B2C3D4, 1, -1, 1'b0, -1); // R4 long@3 write
    do_op(32'h0000_3002, 2'd2, 1'b0, 1'b0, 32'h0, 2, -1, 1'b0, -1);   // R2 long@2
    do_op(32'h0000_4003, 2'd1, 1'b0, 1'b0, 32'h0, 0, -1, 1'b0, -1);   // R2 word@3
    do_op(32'h0000_5001, 2'd1, 1'b1, 1'b0, 32'h0000_5A6B, 0, -1, 1'b0, -1); // R4 word@1 write
    do_op(32'h0000_6003, 2'd0, 1'b0, 1'b0, 32'h0, 0, -1, 1'b0, -1);   // R1 byte@3
    do_op(32'h0000_7000, 2'd2, 1'b0, 1'b0, 32'h0, 0, -1, 1'b0, -1);   // R1 aligned long
    do_op(32'h0000_8007, 2'd2, 1'b0, 1'b1, 32'h0, 0, -1, 1'b0, -1);   // R7 odd fetch
    do_op(32'h0000_9006, 2'd2, 1'b0, 1'b1, 32'h0, 0, -1, 1'b0, -1);   // R7 even fetch splits
    do_op(32'h0000_A001, 2'd2, 1'b0, 1'b0, 32'h0, 0, 1, 1'b0, -1);    // R8 error mid-sequence
    do_op(32'h0000_B002, 2'd1, 1'b1, 1'b0, 32'h1234, 0, 0, 1'b1, -1); // R8 err with ack
    do_op(32'h0000_C001, 2'd2, 1'b0, 1'b0, 32'h0, TO-1, -1, 1'b0, -1);// R9 ack on expiry cycle
    do_op(32'h0000_D003, 2'd2, 1'b1, 1'b0, 32'h55667788, 0, -1, 1'b0, 2); // R9 timeout last xfer

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, w;
      logic [1:0]  sz;
      int          e, tmo;
      a   = $urandom & 32'h7FFF_FFFF;
      sz  = 2'($urandom % 3);
      w   = $urandom;
      e   = ($urandom % 6 == 0) ? int'($urandom % 3) : -1;
      tmo = ($urandom % 25 == 0) ? 0 : -1;
      do_op(a, sz, 1'($urandom), ($urandom % 8 == 0), w, int'($urandom % 4), e,
            1'($urandom), tmo);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule